// File: doc/BRIEF.md
# CRC-Protected SPI Register Frame Engine

This block is an SPI master that carries out one register transaction with a sensor that answers one frame late. The host supplies a 5-bit register address, a write flag and 16 bits of write data, then pulses a start input. The engine builds a 32-bit command frame, shifts it out, and releases chip select. It waits a fixed guard interval and then clocks a second frame, in which it drives zeros and collects the sensor's answer.

Every frame holds a command byte, a 16-bit data word sent high byte first, and a check byte. The check byte is the bitwise inverse of a CRC-8 with polynomial 0x1D. The CRC register starts at 0xFF and covers the first three bytes, most significant bit first. The engine checks the reply against the same rule and reports a mismatch. It also extracts the 2-bit return status and returns the reply data sign-extended to the output width. A one-cycle done pulse marks the update of the results. The engine stays busy until the guard interval after the reply frame has also elapsed, so back-to-back transactions always respect the spacing.

Top module: `crc_frame_master`

## Requirements
- R1: Frames are 32 bits, most significant bit first, in SPI mode 0. sclk idles low and is low whenever csN is high. mosi changes only when sclk falls or while csN is high. miso is sampled on the rising sclk edge. Each half period of sclk lasts CLK_DIV system clocks.
- R2: Command byte (frame bits 31:24) = {writeEn, regAddr[4:0], 2'b00}, so bit 7 is 1 for a write and 0 for a read.
- R3: Frame bits 23:8 carry wrData (bits 23:16 = wrData[15:8]) on a write and all zeros on a read.
- R4: Frame bits 7:0 equal the inverse of a CRC-8 over bits 31:8. The polynomial is 0x1D, the register is preset to 0xFF and the bits are processed MSB first.
- R5: A transaction is exactly two chip-select frames: the command frame, then a reply frame with mosi held at 0. Results come only from the bits received in the reply frame; whatever arrives during the command frame has no effect on them.
- R6: crcErr is 1 when reply bits 7:0 differ from the R4 check value of reply bits 31:8, and 0 otherwise.
- R7: status equals reply bits 25:24; devErr is 1 exactly when that status is 2'b11.
- R8: rdData is reply bits 23:8 sign-extended to OUT_W bits.
- R9: csN stays high for at least GAP_CYCLES system clocks between the two frames, and for at least GAP_CYCLES clocks after the reply frame before busy falls. csN is low only while busy is high.
- R10: A startReq pulse while busy is high is ignored: no extra frame is sent, and the running transaction keeps its latched command.
- R11: After reset busy=0, done=0, csN=1, sclk=0 and all result outputs are 0. done is a single-cycle pulse, coincides with busy low, and the results change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start pulse, taken only while idle |
| writeEn | input | 1 | 1 = write transaction, 0 = read |
| regAddr | input | 5 | Register address |
| wrData | input | 16 | Write data |
| busy | output | 1 | Transaction in progress, including guard intervals |
| done | output | 1 | One-cycle pulse when the results update |
| rdData | output | OUT_W | Sign-extended reply data |
| status | output | 2 | Reply return status |
| crcErr | output | 1 | Reply check byte mismatch |
| devErr | output | 1 | Return status signals a device error |
| sclk | output | 1 | SPI clock, mode 0 |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the sensor |
| miso | input | 1 | Serial data from the sensor |

## Verification
The checks assume two things about the sensor: miso settles within half an sclk period after sclk falls or csN falls, and startReq and the command inputs are synchronous to clk. The bench's sensor model meets both. It changes miso only on the falling sclk edge or the falling chip-select edge, and the host signals are driven at the falling clk edge. The gap check counts clocks from reset, with the count saturated at GAP_CYCLES. The first frame after reset therefore meets the spacing rule without any prior traffic.

// File: rtl/crc_frame_pkg.sv
package crc_frame_pkg;

  localparam int FRAME_BITS = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int CRC_W      = 8;
  localparam int BODY_W     = FRAME_BITS - CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;
  localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP1,
    ST_RPY,
    ST_GAP2
  } ctrlState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadTx;
    logic clearTx;
    logic shiftTx;
    logic sampleRx;
    logic capture;
  } dpStrobe_t;

  // Inverted CRC-8 over the frame body, MSB first
  function automatic logic [CRC_W-1:0] crcCheck(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = CRC_SEED;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ body[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return ~acc;
  endfunction

endpackage

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_frame_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int GAP_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  output dpStrobe_t strobe,
  output logic      sclk,
  output logic      csN,
  output logic      busy,
  output logic      done
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int BIT_W = $clog2(FRAME_BITS);

  ctrlState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic half;

  logic tick, inFrame, inGap, lastBit, gapEnd;

  always_comb begin
    inFrame = (state == ST_CMD) || (state == ST_RPY);
    inGap   = (state == ST_GAP1) || (state == ST_GAP2);
    tick    = (divCnt == DIV_W'(CLK_DIV - 1));
    lastBit = (bitCnt == BIT_W'(FRAME_BITS - 1));
    gapEnd  = (gapCnt == GAP_W'(GAP_CYCLES - 1));

    strobe.loadTx   = (state == ST_IDLE) && startReq;
    strobe.sampleRx = inFrame && tick && !half;
    strobe.shiftTx  = inFrame && tick && half && !lastBit;
    strobe.clearTx  = (state == ST_GAP1) && gapEnd;
    strobe.capture  = (state == ST_GAP2) && gapEnd;

    sclk = inFrame && half;
    csN  = !inFrame;
    busy = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      gapCnt <= '0;
      half   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= strobe.capture;

      if (inFrame) divCnt <= tick ? '0 : divCnt + 1'b1;
      else         divCnt <= '0;

      if (inFrame && tick) half <= ~half;
      else if (!inFrame)   half <= 1'b0;

      if (inFrame && tick && half) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      else if (!inFrame)           bitCnt <= '0;

      if (inGap) gapCnt <= gapEnd ? '0 : gapCnt + 1'b1;
      else       gapCnt <= '0;

      unique case (state)
        ST_IDLE: if (startReq) state <= ST_CMD;
        ST_CMD:  if (tick && half && lastBit) state <= ST_GAP1;
        ST_GAP1: if (gapEnd) state <= ST_RPY;
        ST_RPY:  if (tick && half && lastBit) state <= ST_GAP2;
        ST_GAP2: if (gapEnd) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/crc_frame_dp.sv
module crc_frame_dp
  import crc_frame_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [OUT_W-1:0]  rdData,
  output logic [1:0]        status,
  output logic              crcErr,
  output logic              devErr
);

  localparam int PAD_W = OUT_W - DATA_W;

  logic [FRAME_BITS-1:0] txShift, rxShift;
  logic [7:0]            cmdByte;
  logic [DATA_W-1:0]     payload;
  logic [DATA_W-1:0]     rxData;

  always_comb begin
    cmdByte = {writeEn, regAddr, 2'b00};
    payload = writeEn ? wrData : '0;
    rxData  = rxShift[CRC_W +: DATA_W];
    mosi    = txShift[FRAME_BITS-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
      status  <= '0;
      crcErr  <= 1'b0;
      devErr  <= 1'b0;
    end else begin
      if (strobe.loadTx)
        txShift <= {cmdByte, payload, crcCheck({cmdByte, payload})};
      else if (strobe.clearTx)
        txShift <= '0;
      else if (strobe.shiftTx)
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};

      if (strobe.sampleRx)
        rxShift <= {rxShift[FRAME_BITS-2:0], miso};

      if (strobe.capture) begin
        rdData <= {{PAD_W{rxData[DATA_W-1]}}, rxData};
        status <= rxShift[FRAME_BITS-7 -: 2];
        devErr <= &rxShift[FRAME_BITS-7 -: 2];
        crcErr <= (rxShift[CRC_W-1:0] != crcCheck(rxShift[FRAME_BITS-1:CRC_W]));
      end
    end
  end

endmodule

// File: rtl/crc_frame_master.sv
module crc_frame_master
  import crc_frame_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int GAP_CYCLES = 1000,
  parameter int OUT_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic [OUT_W-1:0]  rdData,
  output logic [1:0]        status,
  output logic              crcErr,
  output logic              devErr,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);

  dpStrobe_t strobe;

  crc_frame_ctrl #(.CLK_DIV(CLK_DIV), .GAP_CYCLES(GAP_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .strobe(strobe),
    .sclk(sclk), .csN(csN), .busy(busy), .done(done)
  );

  crc_frame_dp #(.OUT_W(OUT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .writeEn(writeEn),
    .regAddr(regAddr), .wrData(wrData), .miso(miso), .mosi(mosi),
    .rdData(rdData), .status(status), .crcErr(crcErr), .devErr(devErr)
  );

endmodule

// File: rtl/crc_frame_checker.sv
module crc_frame_checker #(
  parameter int GAP_CYCLES = 1000,
  parameter int OUT_W      = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic [OUT_W-1:0] rdData,
  input logic [1:0]       status,
  input logic             crcErr,
  input logic             sclk,
  input logic             csN,
  input logic             mosi
);

  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  logic [GAP_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= GAP_W'(GAP_CYCLES);
    else if (!csN) highCnt <= '0;
    else if (highCnt < GAP_W'(GAP_CYCLES)) highCnt <= highCnt + 1'b1;
  end

  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_mosi_setup_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(mosi));

  assert_cs_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  assert_frame_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (highCnt >= GAP_W'(GAP_CYCLES)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(rdData) && $stable(status) && $stable(crcErr)));

endmodule

bind crc_frame_master crc_frame_checker #(.GAP_CYCLES(GAP_CYCLES), .OUT_W(OUT_W)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .rdData(rdData),
  .status(status), .crcErr(crcErr), .sclk(sclk), .csN(csN), .mosi(mosi)
);

// File: tb/test_crc_frame_master.sv
module test_crc_frame_master;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int GAP        = 40;
  localparam int OW         = 32;

  logic clk = 0, rstN = 0, startReq = 0, writeEn = 0, miso = 0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic busy, done, crcErr, devErr, sclk, csN, mosi;
  logic [OW-1:0] rdData;
  logic [1:0] status;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_frame_master #(.CLK_DIV(DIV), .GAP_CYCLES(GAP), .OUT_W(OW)) i_crc_frame_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .writeEn(writeEn),
    .regAddr(regAddr), .wrData(wrData), .busy(busy), .done(done),
    .rdData(rdData), .status(status), .crcErr(crcErr), .devErr(devErr),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  // Sensor model
  logic [31:0] rep1 = '0, rep2 = '0, curRep = '0, capt = '0;
  logic [31:0] mosiLog [0:63];
  int gapLog [0:63];
  int frameCount = 0, baseCount = 0, bitIdx = 0, highRun = 0;

  always @(negedge csN) if (rstN) begin
    curRep = (frameCount == baseCount) ? rep1 : rep2;
    bitIdx = 0;
    capt   = '0;
    miso   = curRep[31];
  end

  always @(posedge sclk) if (!csN) capt = {capt[30:0], mosi};

  always @(negedge sclk) if (!csN) begin
    bitIdx++;
    if (bitIdx < 32) miso = curRep[31 - bitIdx];
  end

  always @(posedge csN) if (rstN) begin
    mosiLog[frameCount % 64] = capt;
    frameCount++;
  end

  always @(posedge clk) begin
    if (csN) highRun++;
    else begin
      if (highRun > 0) gapLog[frameCount % 64] = highRun;
      highRun = 0;
    end
  end

  function automatic logic [7:0] refCrc(input logic [23:0] body);
    logic [7:0] r = 8'hFF;
    for (int b = 2; b >= 0; b--) begin
      r = r ^ body[b*8 +: 8];
      for (int k = 0; k < 8; k++)
        r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
    end
    return ~r;
  endfunction

  function automatic logic [31:0] mkReply(input logic [1:0] st, input logic [15:0] d, input bit bad);
    logic [7:0] b0 = {6'b010011, st};
    logic [7:0] c  = refCrc({b0, d});
    return {b0, d, bad ? (c ^ 8'h5A) : c};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One transaction; optional second start while busy
  task automatic runXact(input logic w, input logic [4:0] a, input logic [15:0] d,
                         input logic [31:0] r1, input logic [31:0] r2, input bit midStart);
    logic [7:0]  b0;
    logic [15:0] pay;
    logic [31:0] expCmd;
    bit got = 0;
    b0     = {w, a, 2'b00};
    pay    = w ? d : 16'h0;
    expCmd = {b0, pay, refCrc({b0, pay})};
    rep1 = r1; rep2 = r2; baseCount = frameCount;
    @(negedge clk);
    writeEn = w; regAddr = a; wrData = d; startReq = 1;
    @(negedge clk);
    startReq = 0;
    if (midStart) begin
      repeat (60) @(negedge clk);
      writeEn = ~w; regAddr = ~a; wrData = ~d; startReq = 1;
      @(negedge clk);
      startReq = 0;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    chk("R11", "done seen", 32'(got), 32'd1);
    chk("R11", "busy low with done", 32'(busy), 32'd0);
    chk("R5", "frame count", frameCount - baseCount, 32'd2);
    chk("R10", "frame count with extra start", 32'(frameCount - baseCount == 2), 32'd1);
    chk("R2", "command frame", mosiLog[baseCount % 64], expCmd);
    chk("R5", "reply frame mosi", mosiLog[(baseCount + 1) % 64], 32'h0);
    chk("R9", "inter-frame gap ok", 32'(gapLog[(baseCount + 1) % 64] >= GAP), 32'd1);
    chk("R9", "tail gap ok", 32'(highRun >= GAP), 32'd1);
    chk("R7", "status", 32'(status), 32'(r2[25:24]));
    chk("R7", "devErr", 32'(devErr), 32'(r2[25:24] == 2'b11));
    chk("R6", "crcErr", 32'(crcErr), 32'(r2[7:0] != refCrc(r2[31:8])));
    chk("R8", "rdData", rdData, {{16{r2[23]}}, r2[23:8]});
    @(negedge clk);
    chk("R11", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic testReset;
    chk("R11", "busy", 32'(busy), 0);
    chk("R11", "done", 32'(done), 0);
    chk("R11", "csN", 32'(csN), 1);
    chk("R1", "sclk idle", 32'(sclk), 0);
    chk("R11", "rdData", rdData, 0);
  endtask

  task automatic testWrite;     // R2 R3 R4 R1 write frame
    runXact(1'b1, 5'h0D, 16'h0020, mkReply(2'b01, 16'h1234, 0), mkReply(2'b01, 16'h0000, 0), 0);
  endtask

  task automatic testReadPositive;  // R3 R8, command-frame reply ignored (R5)
    runXact(1'b0, 5'h10, 16'hBEEF, mkReply(2'b11, 16'h8000, 1), mkReply(2'b01, 16'h0051, 0), 0);
  endtask

  task automatic testReadNegative;  // R8 sign extension
    runXact(1'b0, 5'h01, 16'h0000, mkReply(2'b00, 16'h0000, 0), mkReply(2'b01, 16'hFF38, 0), 0);
  endtask

  task automatic testBadCrc;        // R6
    runXact(1'b0, 5'h02, 16'h0000, mkReply(2'b01, 16'h0000, 0), mkReply(2'b01, 16'h7FFF, 1), 0);
  endtask

  task automatic testDevError;      // R7
    runXact(1'b0, 5'h06, 16'h0000, mkReply(2'b01, 16'h0000, 0), mkReply(2'b11, 16'h0155, 0), 0);
  endtask

  task automatic testStartWhileBusy; // R10
    runXact(1'b1, 5'h1F, 16'hA5C3, mkReply(2'b01, 16'h0000, 0), mkReply(2'b10, 16'h00FF, 0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testWrite();
    testReadPositive();
    testReadNegative();
    testBadCrc();
    testDevError();
    testStartWhileBusy();
    testReadPositive();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule